// File: doc/BRIEF.md
# Dual-Clock Debug Communications Mailbox

The block passes single words in both directions between a processor running on one clock and a debug agent running on an unrelated clock. It has two data registers. The outbound register is loaded by the processor and drained by the debugger. The inbound register is loaded by the debugger and drained by the processor. Each register has a pending flag. W marks an outbound word that is waiting. R marks an inbound word that is waiting. The setting side raises a flag and the opposite side clears it.

Each side reads a status word built from its own synchronized view of both flags. Before it sends, a sender polls until the matching flag reads clear. Instead of polling, the processor can use two level interrupts. One says that the outbound register may be loaded. The other says that an inbound word is waiting. The debugger side is a plain parallel register port in the debug clock domain.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both status words read zero, both data outputs read zero, tx_irq_o is 1 and rx_irq_o is 0.
- R2: A processor write while the processor view of W is clear stores cpu_wdata_i and sets W in cpu_status_o on the next processor clock. The debugger sees W in dbg_status_o within 3 debug clock cycles, and dbg_rdata_o then shows the stored word.
- R3: A debugger read while the debugger view of W is set clears W in dbg_status_o on the next debug clock. The processor sees W clear after synchronization.
- R4: A debugger write while the debugger view of R is clear stores dbg_wdata_i and sets R in dbg_status_o on the next debug clock. The processor then sees R set, and cpu_rdata_o shows the stored word.
- R5: A processor read while the processor view of R is set clears R in both views after synchronization.
- R6: A write while the writer's own view of the flag is set is ignored: the held word and both flags are unchanged.
- R7: A read while the reader's own view of the flag is clear returns the held, stale word and changes no flag.
- R8: Both status words have the layout bit 0 = R and bit 1 = W, and all other bits read zero.
- R9: tx_irq_o is 1 exactly while the processor view of W is clear. rx_irq_o is 1 exactly while the processor view of R is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_i | input | 1 | Processor clock |
| dbg_clk_i | input | 1 | Debug clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| cpu_wr_i | input | 1 | Processor write strobe for the outbound register |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_rd_i | input | 1 | Processor read strobe for the inbound register |
| cpu_rdata_o | output | 32 | Inbound register contents |
| cpu_status_o | output | 32 | Processor view of the status word |
| tx_irq_o | output | 1 | Outbound register may be loaded |
| rx_irq_o | output | 1 | Inbound word waiting |
| dbg_wr_i | input | 1 | Debugger write strobe for the inbound register |
| dbg_wdata_i | input | 32 | Debugger write data |
| dbg_rd_i | input | 1 | Debugger read strobe for the outbound register |
| dbg_rdata_o | output | 32 | Outbound register contents |
| dbg_status_o | output | 32 | Debugger view of the status word |

## Verification
The assertions check several properties on every clock of their domain. An accepted write raises the writer's own view of its flag on the next cycle. A flag drops only after the opposite side's read strobe and rises only after the owner's write strobe. A write into a full register leaves the held word stable. The status layout and the interrupt levels must agree with the processor view. Only the bench scenarios can show the end-to-end behaviour across the two clocks. These cover the bound on synchronization latency, stale reads of an empty register, the word that arrives on the far side, and long random mixes of operations checked against a model of both flags and both words.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;
  localparam int unsigned STAT_R_BIT = 0;
  localparam int unsigned STAT_W_BIT = 1;

  function automatic logic [31:0] pack_status(input logic r, input logic w);
    logic [31:0] s;
    s = '0;
    s[STAT_R_BIT] = r;
    s[STAT_W_BIT] = w;
    return s;
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/mbox_dir.sv
// One direction of the mailbox: data word plus a toggle-pair flag.
module mbox_dir #(
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          full_w_o,
  output logic          full_r_o
);
  logic          set_t, clr_t;
  logic          clr_t_w, set_t_r;
  logic [DW-1:0] data_q;

  mbox_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(clr_t), .q_o(clr_t_w)
  );
  mbox_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(set_t), .q_o(set_t_r)
  );

  assign full_w_o = set_t ^ clr_t_w;
  assign full_r_o = set_t_r ^ clr_t;

  // data is loaded together with the toggle; it stays stable until the
  // writer sees the clear, so the reader may sample it freely
  always_ff @(posedge wclk_i or negedge rst_ni)
    if (!rst_ni) begin
      set_t  <= 1'b0;
      data_q <= '0;
    end else if (wr_i && !full_w_o) begin
      set_t  <= ~set_t;
      data_q <= wdata_i;
    end

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni)                clr_t <= 1'b0;
    else if (rd_i && full_r_o)  clr_t <= ~clr_t;

  assign data_o = data_q;
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mbox_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          cpu_clk_i,
  input  logic          dbg_clk_i,
  input  logic          rst_ni,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_rd_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [DW-1:0] cpu_status_o,
  output logic          tx_irq_o,
  output logic          rx_irq_o,
  input  logic          dbg_wr_i,
  input  logic [DW-1:0] dbg_wdata_i,
  input  logic          dbg_rd_i,
  output logic [DW-1:0] dbg_rdata_o,
  output logic [DW-1:0] dbg_status_o
);
  localparam int unsigned NDIR = 2;  // 0: outbound (W), 1: inbound (R)

  logic [NDIR-1:0] full_w, full_r;
  logic [31:0]     cpu_stat_w, dbg_stat_w;

  // outbound: processor writes, debugger reads
  mbox_dir #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_out (
    .wclk_i(cpu_clk_i), .rclk_i(dbg_clk_i), .rst_ni(rst_ni),
    .wr_i(cpu_wr_i), .wdata_i(cpu_wdata_i), .rd_i(dbg_rd_i),
    .data_o(dbg_rdata_o), .full_w_o(full_w[0]), .full_r_o(full_r[0])
  );

  // inbound: debugger writes, processor reads
  mbox_dir #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_in (
    .wclk_i(dbg_clk_i), .rclk_i(cpu_clk_i), .rst_ni(rst_ni),
    .wr_i(dbg_wr_i), .wdata_i(dbg_wdata_i), .rd_i(cpu_rd_i),
    .data_o(cpu_rdata_o), .full_w_o(full_w[1]), .full_r_o(full_r[1])
  );

  // processor view: own side of outbound, far side of inbound
  assign cpu_stat_w = pack_status(full_r[1], full_w[0]);
  assign dbg_stat_w = pack_status(full_w[1], full_r[0]);

  generate
    if (DW >= 32) begin : g_wide
      assign cpu_status_o = {{(DW-32){1'b0}}, cpu_stat_w};
      assign dbg_status_o = {{(DW-32){1'b0}}, dbg_stat_w};
    end else begin : g_narrow
      assign cpu_status_o = cpu_stat_w[DW-1:0];
      assign dbg_status_o = dbg_stat_w[DW-1:0];
    end
  endgenerate

  assign tx_irq_o = ~full_w[0];
  assign rx_irq_o = full_r[1];
endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
  parameter int unsigned DW = 32
) (
  input logic          cpu_clk_i,
  input logic          dbg_clk_i,
  input logic          rst_ni,
  input logic          cpu_wr_i,
  input logic          cpu_rd_i,
  input logic [DW-1:0] cpu_rdata_o,
  input logic [DW-1:0] cpu_status_o,
  input logic          tx_irq_o,
  input logic          rx_irq_o,
  input logic          dbg_wr_i,
  input logic          dbg_rd_i,
  input logic [DW-1:0] dbg_rdata_o,
  input logic [DW-1:0] dbg_status_o
);
  assert_w_set_R2: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    cpu_wr_i && !cpu_status_o[1] |=> cpu_status_o[1]);

  assert_w_rise_R2: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    $rose(cpu_status_o[1]) |-> $past(cpu_wr_i));

  assert_w_fall_R3: assert property (@(posedge dbg_clk_i) disable iff (!rst_ni)
    $fell(dbg_status_o[1]) |-> $past(dbg_rd_i));

  assert_r_set_R4: assert property (@(posedge dbg_clk_i) disable iff (!rst_ni)
    dbg_wr_i && !dbg_status_o[0] |=> dbg_status_o[0]);

  assert_r_fall_R5: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    $fell(cpu_status_o[0]) |-> $past(cpu_rd_i));

  assert_out_hold_R6: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    cpu_wr_i && cpu_status_o[1] |=> $stable(dbg_rdata_o));

  assert_in_hold_R6: assert property (@(posedge dbg_clk_i) disable iff (!rst_ni)
    dbg_wr_i && dbg_status_o[0] |=> $stable(cpu_rdata_o));

  assert_layout_R8: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    cpu_status_o[DW-1:2] == '0 && dbg_status_o[DW-1:2] == '0);

  assert_irq_R9: assert property (@(posedge cpu_clk_i) disable iff (!rst_ni)
    (tx_irq_o == !cpu_status_o[1]) && (rx_irq_o == cpu_status_o[0]));
endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DW(DW)) u_chk (
  .cpu_clk_i(cpu_clk_i), .dbg_clk_i(dbg_clk_i), .rst_ni(rst_ni),
  .cpu_wr_i(cpu_wr_i), .cpu_rd_i(cpu_rd_i), .cpu_rdata_o(cpu_rdata_o),
  .cpu_status_o(cpu_status_o), .tx_irq_o(tx_irq_o), .rx_irq_o(rx_irq_o),
  .dbg_wr_i(dbg_wr_i), .dbg_rd_i(dbg_rd_i), .dbg_rdata_o(dbg_rdata_o),
  .dbg_status_o(dbg_status_o)
);

// File: tb/sim_dbg_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_mailbox;
  logic        cpu_clk = 0, dbg_clk = 0, rst_n = 0;
  logic        cpu_wr = 0, cpu_rd = 0, dbg_wr = 0, dbg_rd = 0;
  logic [31:0] cpu_wdata = '0, dbg_wdata = '0;
  logic [31:0] cpu_rdata, cpu_status, dbg_rdata, dbg_status;
  logic        tx_irq, rx_irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model
  logic        m_w = 0, m_r = 0;
  logic [31:0] m_out = '0, m_in = '0;

  always #2 cpu_clk = ~cpu_clk;   // 250 MHz
  always #5 dbg_clk = ~dbg_clk;   // 100 MHz

  dbg_mailbox u0 (
    .cpu_clk_i(cpu_clk), .dbg_clk_i(dbg_clk), .rst_ni(rst_n),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd),
    .cpu_rdata_o(cpu_rdata), .cpu_status_o(cpu_status),
    .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
    .dbg_wr_i(dbg_wr), .dbg_wdata_i(dbg_wdata), .dbg_rd_i(dbg_rd),
    .dbg_rdata_o(dbg_rdata), .dbg_status_o(dbg_status)
  );

  function automatic logic [31:0] exp_stat(input logic r, input logic w);
    return {30'b0, w, r};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge dbg_clk);
    @(negedge cpu_clk);
  endtask

  task automatic check_all(input string req);
    chk({req, "/R8 cpu status"}, cpu_status, exp_stat(m_r, m_w));
    chk({req, "/R8 dbg status"}, dbg_status, exp_stat(m_r, m_w));
    chk({req, "/R9 tx_irq"}, {31'b0, tx_irq}, {31'b0, !m_w});
    chk({req, "/R9 rx_irq"}, {31'b0, rx_irq}, {31'b0, m_r});
    chk({req, " out word"}, dbg_rdata, m_out);
    chk({req, " in word"}, cpu_rdata, m_in);
  endtask

  task automatic cpu_write(input logic [31:0] d);
    @(negedge cpu_clk); cpu_wr = 1; cpu_wdata = d;
    @(negedge cpu_clk); cpu_wr = 0;
    if (!m_w) begin m_w = 1; m_out = d; end
  endtask

  task automatic dbg_write(input logic [31:0] d);
    @(negedge dbg_clk); dbg_wr = 1; dbg_wdata = d;
    @(negedge dbg_clk); dbg_wr = 0;
    if (!m_r) begin m_r = 1; m_in = d; end
  endtask

  task automatic cpu_read(input string req);
    @(negedge cpu_clk); chk({req, " cpu read data"}, cpu_rdata, m_in);
    cpu_rd = 1;
    @(negedge cpu_clk); cpu_rd = 0;
    m_r = 0;
  endtask

  task automatic dbg_read(input string req);
    @(negedge dbg_clk); chk({req, " dbg read data"}, dbg_rdata, m_out);
    dbg_rd = 1;
    @(negedge dbg_clk); dbg_rd = 0;
    m_w = 0;
  endtask

  initial begin
    repeat (200000) @(posedge cpu_clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #23 rst_n = 1;
    settle();
    check_all("R1 reset");

    // R2: processor view is immediate, debugger view within 3 debug cycles
    cpu_write(32'hA5A5_0001);
    chk("R2 cpu W next cycle", cpu_status, exp_stat(0, 1));
    repeat (3) @(negedge dbg_clk);
    chk("R2 dbg W synced", dbg_status, exp_stat(0, 1));
    chk("R2 dbg word", dbg_rdata, 32'hA5A5_0001);
    settle(); check_all("R2");

    // R6: write into full outbound register
    cpu_write(32'hDEAD_BEEF);
    settle(); check_all("R6 outbound full");

    // R3
    dbg_read("R3");
    chk("R3 dbg W cleared", dbg_status, exp_stat(0, 0));
    settle(); check_all("R3");

    // R7: stale reads on empty registers
    dbg_read("R7 stale out");
    settle(); check_all("R7 out");
    cpu_read("R7 stale in");
    settle(); check_all("R7 in");

    // R4 / R6 / R5 on the inbound side
    dbg_write(32'h1234_5678);
    chk("R4 dbg R next cycle", dbg_status, exp_stat(1, 0));
    settle(); check_all("R4");
    dbg_write(32'h0BAD_F00D);
    settle(); check_all("R6 inbound full");
    cpu_read("R5");
    settle(); check_all("R5");

    // both directions full at once
    cpu_write(32'hFFFF_FFFF);
    dbg_write(32'h0000_0001);
    settle(); check_all("R2/R4 both full");
    cpu_read("R5 both");
    dbg_read("R3 both");
    settle(); check_all("R3/R5 both empty");

    // random mix
    for (int i = 0; i < 300; i++) begin
      automatic int unsigned op = $urandom_range(3, 0);
      automatic logic [31:0] d = $urandom;
      case (op)
        0: cpu_write(d);
        1: dbg_write(d);
        2: cpu_read("R5/R7 rand");
        default: dbg_read("R3/R7 rand");
      endcase
      settle();
      check_all("rand");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule